// File: doc/BRIEF.md
# Dual-View ROM Bank Mapper

This block turns a 24-bit processor bus address into a 23-bit physical ROM byte address using four programmable 8-bit bank registers. Each register selects one 1 MB region of an 8 MB ROM. The block sits between the processor address bus and the ROM array. Storage, wait states and any other memory decode belong to the surrounding logic.

Two address views share the same registers, and an input picks one of them. In the paged view, each bank exposes a 32 KB window in its upper half. Bit 7 of a register decides whether that register's base replaces the identity mapping. In the linear view, four 1 MB slices cover the upper quarter of the bus, and each slice always takes its base from its register. The registers are written and read through a small configuration port whose offsets run from 0 to 7. Only offsets 4 to 7 are mapped.

Top module: `dual_view_bank_mapper`

## Requirements
- R1: After a synchronous active-low reset, bank register n holds the value n for n = 0..3. Reading offset 4+n then returns n, and both views start as an identity mapping.
- R2: A write with `cfg_wr` = 1 at offset 4+n stores all 8 bits of `cfg_wdata` into register n. Reading offset 4+n returns the full 8-bit value, including bits 6:3, which no view uses.
- R3: Offsets 0 to 3 are outside the register window. Reads there return 0x00, and writes there change no register and no mapping.
- R4: Paged view (`view_linear` = 0): the register index is bus address bits 22:21. When bit 7 of that register is 0, the base placed in `rom_addr[22:20]` is the index itself, whatever register bits 2:0 hold.
- R5: Paged view: when bit 7 of the selected register is 1, the base is register bits 2:0.
- R6: Paged view: the byte offset inside the 1 MB region is {A[20:16], A[14:0]}. Bus bits 23 and 15 do not affect the result. In both views, `rom_addr[14:0]` equals bus bits 14:0, and `rom_addr` = base × 1 MB + offset.
- R7: Linear view (`view_linear` = 1): the register index is bus bits 21:20 and the base is always register bits 2:0, whatever bit 7 holds. The offset is bus bits 19:0, and bus bits 23:22 are ignored.
- R8: A register write takes effect at the clock edge that captures it. In the cycle of the write, both the translation and the read-back still see the old value. Without a write, `rom_addr` depends only on the current bus address and view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 3 | Configuration offset; 4 to 7 select registers 0 to 3 |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| bus_addr | input | 24 | Processor bus address to translate |
| view_linear | input | 1 | 0 = paged view, 1 = linear view |
| rom_addr | output | 23 | Physical ROM byte address (combinational) |

## Verification
A register write and a translation, or a read-back, that uses the same register can happen in the same cycle. The bench provokes this by holding a write to register 3 on the port while the bus address selects bank 3 and `cfg_addr` points at the same offset. It checks before the capturing edge that both outputs still show the old mapping. It then checks just after the edge that both show the new value. A mid-run reset also follows earlier writes, to show that the identity values return.

// File: rtl/bankmap_pkg.sv
// Package bankmap_pkg
// Shared widths and the view encoding of the dual-view bank mapper.
// Assumes a byte-addressed ROM of 2**(BM_BASE_W + BM_REGION_W) bytes.
package bankmap_pkg;
    localparam int unsigned BM_BANKS     = 4;
    localparam int unsigned BM_REG_W     = 8;
    localparam int unsigned BM_BUS_W     = 24;
    localparam int unsigned BM_REGION_W  = 20;
    localparam int unsigned BM_BASE_W    = 3;
    localparam int unsigned BM_WIN_W     = 15;
    localparam int unsigned BM_CFG_W     = 3;
    localparam int unsigned BM_CFG_FIRST = 4;
    localparam int unsigned BM_ROM_W     = BM_BASE_W + BM_REGION_W;

    typedef enum logic {
        VIEW_PAGED  = 1'b0,
        VIEW_LINEAR = 1'b1
    } bm_view_e;
endpackage

// File: rtl/bankmap_regfile.sv
// Module bankmap_regfile
// Holds the bank registers and serves the configuration write and read port.
// Register n sits at offset CFG_FIRST+n and resets to the value n.
// Offsets outside that window read as zero, and writes to them are dropped.
// Read data is combinational, so a read in the cycle of a write shows the old value.
module bankmap_regfile #(
    parameter int unsigned NUM       = 4,
    parameter int unsigned REG_W     = 8,
    parameter int unsigned CFG_W     = 3,
    parameter int unsigned CFG_FIRST = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [CFG_W-1:0]          cfg_addr,
    input  logic [REG_W-1:0]          wdata,
    output logic [REG_W-1:0]          rdata,
    output logic [NUM-1:0][REG_W-1:0] regs_o
);
    localparam int unsigned IDX_W = (NUM > 1) ? $clog2(NUM) : 1;

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [CFG_W-1:0] rel;

    // Decode whether the offset falls inside the register window, and which register it names.
    always_comb begin
        rel = cfg_addr - CFG_W'(CFG_FIRST);
        hit = (32'(cfg_addr) >= CFG_FIRST) && (32'(cfg_addr) < CFG_FIRST + NUM);
        idx = IDX_W'(rel);
    end

    // Return the addressed register, or zero outside the window.
    always_comb begin
        rdata = hit ? regs_o[idx] : '0;
    end

    for (genvar g = 0; g < NUM; g++) begin : g_bank
        logic [REG_W-1:0] q;

        // Reset to the identity value g; load on a write that names this register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= REG_W'(g);
            else if (wr_en && hit && (idx == IDX_W'(g)))
                q <= wdata;
        end

        assign regs_o[g] = q;

        AST_RESET_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (q == REG_W'(g))); // R1
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) |=> (regs_o[$past(idx)] == $past(wdata))); // R2

    AST_OUTSIDE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(regs_o)); // R3
endmodule

// File: rtl/bankmap_xlate.sv
// Module bankmap_xlate
// Combinational translation for one address view, chosen by the LINEAR parameter.
// Paged view: the index is the bits just above the region, the base is taken from
// the register only when its top bit is set, and the window offset skips bus bit WIN_W.
// Linear view: the index is the bits just above the region, and the base always
// comes from the register.
module bankmap_xlate #(
    parameter bit          LINEAR   = 1'b0,
    parameter int unsigned NUM      = 4,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned BUS_W    = 24,
    parameter int unsigned REGION_W = 20,
    parameter int unsigned BASE_W   = 3,
    parameter int unsigned WIN_W    = 15
) (
    input  logic [NUM-1:0][REG_W-1:0]   regs,
    input  logic [BUS_W-1:0]            bus_addr,
    output logic [BASE_W+REGION_W-1:0]  phys
);
    localparam int unsigned IDX_W = (NUM > 1) ? $clog2(NUM) : 1;
    localparam int unsigned HI_W  = REGION_W - WIN_W;

    logic [IDX_W-1:0]    idx;
    logic [REG_W-1:0]    sel;
    logic [BASE_W-1:0]   base;
    logic [REGION_W-1:0] offset;
    logic                unused_bits;

    if (LINEAR) begin : g_linear
        // Linear view: index above the region, base always from the register.
        always_comb begin
            idx    = bus_addr[REGION_W +: IDX_W];
            sel    = regs[idx];
            base   = sel[BASE_W-1:0];
            offset = bus_addr[REGION_W-1:0];
        end
    end else begin : g_paged
        // Paged view: index one bit higher, and the top register bit chooses override or identity.
        always_comb begin
            idx    = bus_addr[REGION_W+1 +: IDX_W];
            sel    = regs[idx];
            base   = sel[REG_W-1] ? sel[BASE_W-1:0] : BASE_W'(idx);
            offset = {bus_addr[REGION_W -: HI_W], bus_addr[WIN_W-1:0]};
        end
    end

    // Place the base above the region offset.
    always_comb begin
        phys = {base, offset};
    end

    assign unused_bits = ^{bus_addr, regs};
endmodule

// File: rtl/dual_view_bank_mapper.sv
// Module dual_view_bank_mapper
// Top level. The register file feeds two view translators, and view_linear picks
// which result drives rom_addr. The output is combinational from the registers
// and the bus, so a write becomes visible only after the edge that captures it.
module dual_view_bank_mapper
    import bankmap_pkg::*;
#(
    parameter int unsigned NUM       = BM_BANKS,
    parameter int unsigned REG_W     = BM_REG_W,
    parameter int unsigned BUS_W     = BM_BUS_W,
    parameter int unsigned REGION_W  = BM_REGION_W,
    parameter int unsigned BASE_W    = BM_BASE_W,
    parameter int unsigned WIN_W     = BM_WIN_W,
    parameter int unsigned CFG_W     = BM_CFG_W,
    parameter int unsigned CFG_FIRST = BM_CFG_FIRST,
    localparam int unsigned ROM_W    = BASE_W + REGION_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic             view_linear,
    output logic [ROM_W-1:0] rom_addr
);
    localparam int unsigned IDX_W = (NUM > 1) ? $clog2(NUM) : 1;

    logic [NUM-1:0][REG_W-1:0] bank_regs;
    logic [ROM_W-1:0]          paged_phys;
    logic [ROM_W-1:0]          linear_phys;
    bm_view_e                  view;

    bankmap_regfile #(
        .NUM(NUM), .REG_W(REG_W), .CFG_W(CFG_W), .CFG_FIRST(CFG_FIRST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .cfg_addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .regs_o(bank_regs)
    );

    bankmap_xlate #(
        .LINEAR(1'b0), .NUM(NUM), .REG_W(REG_W), .BUS_W(BUS_W),
        .REGION_W(REGION_W), .BASE_W(BASE_W), .WIN_W(WIN_W)
    ) u_paged (
        .regs(bank_regs), .bus_addr(bus_addr), .phys(paged_phys)
    );

    bankmap_xlate #(
        .LINEAR(1'b1), .NUM(NUM), .REG_W(REG_W), .BUS_W(BUS_W),
        .REGION_W(REGION_W), .BASE_W(BASE_W), .WIN_W(WIN_W)
    ) u_linear (
        .regs(bank_regs), .bus_addr(bus_addr), .phys(linear_phys)
    );

    // Pick the translation that the requested view asks for.
    always_comb begin
        view     = bm_view_e'(view_linear);
        rom_addr = (view == VIEW_LINEAR) ? linear_phys : paged_phys;
    end

    AST_WINDOW_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[WIN_W-1:0] == bus_addr[WIN_W-1:0]); // R6

    AST_PAGED_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (!view_linear && !bank_regs[bus_addr[REGION_W+1 +: IDX_W]][REG_W-1])
        |-> (rom_addr[ROM_W-1 -: BASE_W] == BASE_W'(bus_addr[REGION_W+1 +: IDX_W]))); // R4

    AST_PAGED_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!view_linear && bank_regs[bus_addr[REGION_W+1 +: IDX_W]][REG_W-1])
        |-> (rom_addr[ROM_W-1 -: BASE_W] == bank_regs[bus_addr[REGION_W+1 +: IDX_W]][BASE_W-1:0])); // R5

    AST_LINEAR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        view_linear |-> ((rom_addr[ROM_W-1 -: BASE_W] == bank_regs[bus_addr[REGION_W +: IDX_W]][BASE_W-1:0])
                         && (rom_addr[REGION_W-1:0] == bus_addr[REGION_W-1:0]))); // R7

    AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_wr) && $stable(bus_addr) && $stable(view_linear)) |-> $stable(rom_addr)); // R8
endmodule

// File: tb/tb_dual_view_bank_mapper.sv
`timescale 1ns/1ps
module tb_dual_view_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic [7:0]  cfg_rdata;
    logic [23:0] bus_addr = 24'd0;
    logic        view_linear = 1'b0;
    logic [22:0] rom_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_view_bank_mapper dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_addr(bus_addr),
        .view_linear(view_linear), .rom_addr(rom_addr)
    );

    // {view, bus address, expected ROM address} under the reset identity mapping
    localparam logic [47:0] VEC [10] = '{
        {1'b0, 24'h008000, 23'h000000},  // R6 bus bit 15 ignored
        {1'b0, 24'h00FFFF, 23'h007FFF},  // R6
        {1'b0, 24'h1FFFFF, 23'h0FFFFF},  // R6
        {1'b0, 24'h208000, 23'h100000},  // R4
        {1'b0, 24'h411234, 23'h209234},  // R4
        {1'b0, 24'hE3ABCD, 23'h31ABCD},  // R6 bus bit 23 ignored
        {1'b1, 24'hC00000, 23'h000000},  // R7
        {1'b1, 24'hD54321, 23'h154321},  // R7
        {1'b1, 24'hEFFFFF, 23'h2FFFFF},  // R7
        {1'b1, 24'hFA0001, 23'h3A0001}   // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] off, input logic [7:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = off; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic probe(input logic lin, input logic [23:0] a, input logic [22:0] exp, input string req);
        view_linear = lin; bus_addr = a;
        #1;
        check(req, 32'(rom_addr), 32'(exp));
    endtask

    task automatic readback(input logic [2:0] off, input logic [7:0] exp, input string req);
        cfg_addr = off;
        #1;
        check(req, 32'(cfg_rdata), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int n = 0; n < 4; n++) readback(3'(4 + n), 8'(n), "R1 reset value");

        for (int i = 0; i < 10; i++) probe(VEC[i][47], VEC[i][46:23], VEC[i][22:0], "R4/R6/R7 vector");

        write_reg(3'd5, 8'h85);
        probe(1'b0, 24'h208000, 23'h500000, "R5 paged override");
        probe(1'b1, 24'hD00000, 23'h500000, "R7 linear base");
        write_reg(3'd6, 8'h06);
        probe(1'b0, 24'h408000, 23'h200000, "R4 paged identity with bit7 clear");
        probe(1'b1, 24'hE00000, 23'h600000, "R7 linear ignores bit7");
        write_reg(3'd4, 8'h7B);
        readback(3'd4, 8'h7B, "R2 full 8-bit readback");
        probe(1'b1, 24'hC00000, 23'h300000, "R7 linear base from bits 2:0");
        probe(1'b0, 24'h008000, 23'h000000, "R4 paged identity");

        write_reg(3'd1, 8'hAA);
        readback(3'd1, 8'h00, "R3 outside offset reads zero");
        readback(3'd5, 8'h85, "R3 register untouched");
        probe(1'b0, 24'h208000, 23'h500000, "R3 mapping untouched");

        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 3'd7; cfg_wdata = 8'h81;
        view_linear = 1'b0; bus_addr = 24'h608000;
        #1;
        check("R8 same-cycle map old", 32'(rom_addr), 32'h300000);
        check("R8 same-cycle read old", 32'(cfg_rdata), 32'h03);
        @(posedge clk);
        #1;
        check("R8 map after edge", 32'(rom_addr), 32'h100000);
        check("R8 read after edge", 32'(cfg_rdata), 32'h81);
        @(negedge clk);
        cfg_wr = 1'b0;

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 4; n++) readback(3'(4 + n), 8'(n), "R1 value after second reset");
        probe(1'b0, 24'h208000, 23'h100000, "R1 identity after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule